// File: doc/BRIEF.md
# Lane Alignment Sequence Transmitter

This block sits at the head of one transmit lane of a serial converter link. It produces the alignment preamble that a receiver uses to line up frames and lanes before sample data flows. While the receiver holds the active-low sync request low, the lane carries comma characters. Once sync is released, the block waits for the next multiframe boundary. It then sends four alignment multiframes and after that passes user data through unchanged.

Each lane word is 32 bits wide and holds four octets. Octet 0 is in bits [7:0] and goes first in time, and octet 3 is in bits [31:24]. One flag bit per octet marks a control character. A free-running word counter, started by reset, sets the multiframe boundaries. The multiframe length in octets is a parameter. It must be a multiple of 4 and at least 20, so that a boundary always falls on a word edge and the second multiframe has room for its configuration block. The fourteen configuration octets arrive as one flat vector, with configuration octet n in bits [8n+7:8n].

Top module: `lane_align_tx`

## Requirements
- R1: While reset is active, and afterwards while sync_ni is low, every octet of lane_o is the comma 0xBC and ctrl_o is 4'hF.
- R2: The multiframe word counter runs freely from reset, with period MF_OCTETS/4 words. After sync_ni is seen high, the first alignment word appears right after the last word of the current multiframe. Until then the lane keeps sending commas.
- R3: The first octet (bits [7:0] of word 0) of each alignment multiframe is the start marker 0x1C, with ctrl_o[0] set.
- R4: The last octet (bits [31:24] of the last word) of each alignment multiframe is the end marker 0x7C, with ctrl_o[3] set.
- R5: In the second alignment multiframe, octet 1 (bits [15:8] of word 0) is the configuration marker 0x9C, with ctrl_o[1] set.
- R6: In the second alignment multiframe, octet positions 2 to 15 carry configuration octets 0 to 13 in order, with their flags low.
- R7: Every other alignment octet carries its own octet index within the multiframe (modulo 256) as data, with its flag low.
- R8: The alignment phase is exactly four multiframes long. The word after the last end marker carries data_i unchanged in the same cycle, with ctrl_o at 0, and data_i has no effect on the lane before that word.
- R9: When sync_ni is low at a clock edge, the next word is all commas, whatever phase the block was in. A later release starts again at the first alignment multiframe on the next boundary.
- R10: A flag bit is set exactly when its octet holds a control character. Configuration or data octets whose values happen to equal a marker code keep their flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Synchronization request from the receiver, active low |
| cfg_i | input | 112 | Fourteen configuration octets, octet n in bits [8n+7:8n] |
| data_i | input | 32 | User data word, octet 0 in bits [7:0] |
| lane_o | output | 32 | Lane word, four octets, octet 0 in bits [7:0] |
| ctrl_o | output | 4 | Control-character flag per octet of lane_o |

## Verification
The preamble is run with two configuration patterns. One is a plain ascending set. The other holds the values 0x1C, 0x7C, 0x9C and 0xBC as data. This second set shows whether the flags follow an octet's position or its value. Sync is released at the first, a middle and the last word of a multiframe, which separates starting on the boundary from starting right away. Sync is also dropped in the middle of the configuration multiframe, on the very last end marker, and during user data. Each of these must fall back to commas and later restart from the first multiframe. The user data words come from a varying pattern that is also driven during alignment, so the bench can tell pass-through from data leaking into the preamble.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam logic [7:0] K_START = 8'h1C;
  localparam logic [7:0] K_END   = 8'h7C;
  localparam logic [7:0] K_CFG   = 8'h9C;
  localparam logic [7:0] K_COMMA = 8'hBC;

  localparam int CFG_OCTETS = 14;
  localparam int CFG_MF     = 1;   // index of multiframe carrying configuration

  typedef enum logic [1:0] {
    ST_COMMA = 2'd0,
    ST_ALIGN = 2'd1,
    ST_USER  = 2'd2
  } la_state_e;

  function automatic logic is_ctrl_char(logic [7:0] b);
    return (b == K_START) || (b == K_END) || (b == K_CFG) || (b == K_COMMA);
  endfunction
endpackage

// File: rtl/la_mf_timer.sv
module la_mf_timer #(
  parameter int WPM = 8,
  parameter int WW  = $clog2(WPM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [WW-1:0] word_o,
  output logic          last_o
);
  localparam logic [WW-1:0] LAST_W = WW'(WPM - 1);

  logic [WW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              word_q <= '0;
    else if (word_q == LAST_W) word_q <= '0;
    else                      word_q <= word_q + 1'b1;
  end

  assign word_o = word_q;
  assign last_o = (word_q == LAST_W);
endmodule

// File: rtl/la_seq_ctrl.sv
module la_seq_ctrl
  import lane_align_pkg::*;
#(
  parameter int ALIGN_MFS = 4,
  parameter int MFW       = $clog2(ALIGN_MFS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_ni,
  input  logic           mf_last_i,
  output la_state_e      state_o,
  output logic [MFW-1:0] mf_o
);
  localparam logic [MFW-1:0] LAST_MF = MFW'(ALIGN_MFS - 1);

  la_state_e      state_q;
  logic [MFW-1:0] mf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COMMA;
      mf_q    <= '0;
    end else if (!sync_ni) begin
      state_q <= ST_COMMA;
      mf_q    <= '0;
    end else if (mf_last_i) begin
      case (state_q)
        ST_COMMA: begin
          state_q <= ST_ALIGN;
          mf_q    <= '0;
        end
        ST_ALIGN: begin
          if (mf_q == LAST_MF) state_q <= ST_USER;
          else                 mf_q    <= mf_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign mf_o    = mf_q;
endmodule

// File: rtl/la_octet_gen.sv
module la_octet_gen
  import lane_align_pkg::*;
#(
  parameter int MF_OCTETS = 32,
  parameter int WW        = 3,
  parameter int MFW       = 2
) (
  input  la_state_e               state_i,
  input  logic [MFW-1:0]          mf_i,
  input  logic [WW-1:0]           word_i,
  input  logic [CFG_OCTETS*8-1:0] cfg_i,
  input  logic [31:0]             data_i,
  output logic [31:0]             lane_o,
  output logic [3:0]              ctrl_o
);
  localparam int OW = WW + 2;
  localparam logic [OW-1:0] IDX_END    = OW'(MF_OCTETS - 1);
  localparam logic [OW-1:0] IDX_CFG_LO = OW'(2);
  localparam logic [OW-1:0] IDX_CFG_HI = OW'(CFG_OCTETS + 2);

  logic cfg_mf;
  assign cfg_mf = (mf_i == MFW'(CFG_MF));

  for (genvar k = 0; k < 4; k++) begin : g_oct
    logic [OW-1:0] idx;
    logic [7:0]    cfg_b;
    logic [7:0]    oct;
    logic          kf;

    assign idx = {word_i, 2'(k)};   // octet index within multiframe

    always_comb begin
      cfg_b = '0;
      for (int n = 0; n < CFG_OCTETS; n++) begin
        if (idx == OW'(n + 2)) cfg_b = cfg_i[8*n +: 8];
      end
    end

    always_comb begin
      case (state_i)
        ST_ALIGN: begin
          if (idx == '0)                     {kf, oct} = {1'b1, K_START};
          else if (idx == IDX_END)           {kf, oct} = {1'b1, K_END};
          else if (cfg_mf && idx == OW'(1))  {kf, oct} = {1'b1, K_CFG};
          else if (cfg_mf && idx >= IDX_CFG_LO && idx < IDX_CFG_HI)
                                             {kf, oct} = {1'b0, cfg_b};
          else                               {kf, oct} = {1'b0, 8'(idx)};
        end
        ST_USER:  {kf, oct} = {1'b0, data_i[8*k +: 8]};
        default:  {kf, oct} = {1'b1, K_COMMA};
      endcase
    end

    assign lane_o[8*k +: 8] = oct;
    assign ctrl_o[k]        = kf;
  end
endmodule

// File: rtl/lane_align_tx.sv
module lane_align_tx
  import lane_align_pkg::*;
#(
  parameter int MF_OCTETS = 32,
  parameter int ALIGN_MFS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_ni,
  input  logic [CFG_OCTETS*8-1:0] cfg_i,
  input  logic [31:0]             data_i,
  output logic [31:0]             lane_o,
  output logic [3:0]              ctrl_o
);
  localparam int WPM = MF_OCTETS / 4;
  localparam int WW  = $clog2(WPM);
  localparam int MFW = $clog2(ALIGN_MFS);

  logic [WW-1:0]  word;
  logic           word_last;
  la_state_e      state;
  logic [MFW-1:0] mf;

  la_mf_timer #(.WPM(WPM), .WW(WW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_o (word),
    .last_o (word_last)
  );

  la_seq_ctrl #(.ALIGN_MFS(ALIGN_MFS), .MFW(MFW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_ni   (sync_ni),
    .mf_last_i (word_last),
    .state_o   (state),
    .mf_o      (mf)
  );

  la_octet_gen #(.MF_OCTETS(MF_OCTETS), .WW(WW), .MFW(MFW)) u_gen (
    .state_i (state),
    .mf_i    (mf),
    .word_i  (word),
    .cfg_i   (cfg_i),
    .data_i  (data_i),
    .lane_o  (lane_o),
    .ctrl_o  (ctrl_o)
  );
endmodule

// File: rtl/lane_align_tx_chk.sv
module lane_align_tx_chk
  import lane_align_pkg::*;
#(
  parameter int WPM       = 8,
  parameter int WW        = 3,
  parameter int MFW       = 2,
  parameter int ALIGN_MFS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sync_ni,
  input logic [31:0]    lane_i,
  input logic [3:0]     ctrl_i,
  input la_state_e      state_i,
  input logic [MFW-1:0] mf_i,
  input logic [WW-1:0]  word_i
);
  localparam logic [WW-1:0]  LAST_W  = WW'(WPM - 1);
  localparam logic [MFW-1:0] LAST_MF = MFW'(ALIGN_MFS - 1);

  AST_COMMA_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ni |=> (lane_i == {4{K_COMMA}} && ctrl_i == 4'hF)); // R9

  AST_START_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ALIGN && $past(state_i) == ST_COMMA) |-> (word_i == '0 && mf_i == '0)); // R2

  AST_START_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ALIGN && word_i == '0) |-> (lane_i[7:0] == K_START && ctrl_i[0])); // R3

  AST_END_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ALIGN && word_i == LAST_W) |-> (lane_i[31:24] == K_END && ctrl_i[3])); // R4

  AST_CFG_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ALIGN && mf_i == MFW'(CFG_MF) && word_i == '0)
      |-> (lane_i[15:8] == K_CFG && ctrl_i[1])); // R5

  AST_USER_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_USER && $past(state_i) != ST_USER)
      |-> ($past(state_i) == ST_ALIGN && $past(mf_i) == LAST_MF && $past(word_i) == LAST_W)); // R8

  AST_USER_NO_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_USER) |-> (ctrl_i == 4'h0)); // R8

  for (genvar k = 0; k < 4; k++) begin : g_ctrl
    AST_CTRL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_i[k] |-> is_ctrl_char(lane_i[8*k +: 8])); // R10
  end
endmodule

bind lane_align_tx lane_align_tx_chk #(
  .WPM(WPM), .WW(WW), .MFW(MFW), .ALIGN_MFS(ALIGN_MFS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_ni (sync_ni),
  .lane_i  (lane_o),
  .ctrl_i  (ctrl_o),
  .state_i (state),
  .mf_i    (mf),
  .word_i  (word)
);

// File: tb/lane_align_tx_tb.sv
module lane_align_tx_tb;
  localparam int MF_OCTETS = 32;
  localparam int WPM       = MF_OCTETS / 4;
  localparam int LAST      = WPM - 1;
  localparam int NMF       = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_n = 1'b0;
  logic [111:0] cfg = '0;
  logic [31:0]  data = '0;
  logic [31:0]  lane;
  logic [3:0]   ctrl;

  int n_chk  = 0;
  int n_fail = 0;
  int tb_w   = 0;
  int seed   = 1;

  always #5 clk = ~clk;

  lane_align_tx #(.MF_OCTETS(MF_OCTETS), .ALIGN_MFS(NMF)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sync_ni (sync_n),
    .cfg_i   (cfg),
    .data_i  (data),
    .lane_o  (lane),
    .ctrl_o  (ctrl)
  );

  // multiframe position implied by R2: free-running word count since reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tb_w <= 0;
    else if (tb_w == LAST) tb_w <= 0;
    else                   tb_w <= tb_w + 1;
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [8:0] exp_oct(int mf, int o, logic [111:0] c);
    if (o == 0)                       return {1'b1, 8'h1C};
    if (o == MF_OCTETS - 1)           return {1'b1, 8'h7C};
    if (mf == 1 && o == 1)            return {1'b1, 8'h9C};
    if (mf == 1 && o >= 2 && o <= 15) return {1'b0, c[(o-2)*8 +: 8]};
    return {1'b0, 8'(o)};
  endfunction

  task automatic chk_comma(string tag);
    chk(tag, lane, 32'hBCBC_BCBC);
    chk(tag, {28'h0, ctrl}, 32'hF);
  endtask

  function automatic logic [31:0] next_data();
    seed = seed * 1103515245 + 12345;
    return 32'(seed);
  endfunction

  // release sync at word raise_at; drop at (drop_mf, drop_w) or, if drop_mf<0, after user words
  task automatic t_align(logic [111:0] c, int raise_at, int drop_mf, int drop_w, int n_user);
    logic [31:0] ew;
    logic [3:0]  ek;
    logic [8:0]  eo;
    string       tag;
    cfg = c;
    do @(negedge clk); while (tb_w != raise_at);
    sync_n = 1'b1;
    while (tb_w != LAST) begin
      @(negedge clk);
      chk_comma("R2");
    end
    for (int mf = 0; mf < NMF; mf++) begin
      for (int w = 0; w < WPM; w++) begin
        @(negedge clk);
        data = next_data();
        #1;
        for (int k = 0; k < 4; k++) begin
          eo = exp_oct(mf, 4*w + k, c);
          ew[8*k +: 8] = eo[7:0];
          ek[k] = eo[8];
        end
        if (mf == 1 && w == 0)       tag = "R5";
        else if (w == 0)             tag = "R3";
        else if (w == LAST)          tag = "R4";
        else if (mf == 1 && w <= 3)  tag = "R6";
        else                         tag = "R7";
        chk(tag, lane, ew);
        chk("R10", {28'h0, ctrl}, {28'h0, ek});
        if (mf == drop_mf && w == drop_w) begin
          sync_n = 1'b0;
          @(negedge clk);
          chk_comma("R9");
          return;
        end
      end
    end
    for (int u = 0; u < n_user; u++) begin
      @(negedge clk);
      data = next_data();
      #1;
      chk("R8", lane, data);
      chk("R8", {28'h0, ctrl}, 32'h0);
    end
    sync_n = 1'b0;
    @(negedge clk);
    chk_comma("R9");
  endtask

  task automatic t_reset();
    #1;
    chk_comma("R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2 * WPM; i++) begin
      @(negedge clk);
      data = next_data();
      #1;
      chk_comma("R1");
    end
  endtask

  function automatic logic [111:0] cfg_plain();
    logic [111:0] c;
    for (int n = 0; n < 14; n++) c[8*n +: 8] = 8'(8'h40 + n);
    return c;
  endfunction

  function automatic logic [111:0] cfg_markers();
    logic [111:0] c;
    for (int n = 0; n < 14; n++) c[8*n +: 8] = 8'(8'hF0 - n);
    c[7:0]   = 8'h1C;
    c[15:8]  = 8'h7C;
    c[23:16] = 8'h9C;
    c[31:24] = 8'hBC;
    c[111:104] = 8'hBC;
    return c;
  endfunction

  initial begin
    t_reset();
    t_align(cfg_plain(),   2,    -1, 0, 6);     // mid-multiframe release
    t_align(cfg_markers(), LAST, -1, 0, 4);     // release on last word: start at once
    t_align(cfg_plain(),   0,     1, 3, 0);     // drop inside configuration multiframe
    t_align(cfg_markers(), 5,     3, LAST, 0);  // drop on final end marker
    t_align(cfg_plain(),   4,    -1, 0, 5);     // clean restart after drops
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule